// File: doc/BRIEF.md
# Shared Row/Column Butterfly Front End for an 8-Point Transform

This block is the first arithmetic stage of a one-dimensional 8-point cosine transform engine that serves both passes of a two-dimensional transform. One serial stream carries row samples from the pixel source. A second serial stream carries column samples coming back from the transpose store. Each stream has its own bank of four reorder registers that keeps the first half of an 8-sample vector. A single adder/subtracter pair then forms the mirrored sums and differences for whichever stream has its full vector available.

A free-running 8-cycle phase counter sets the schedule. In phases 0 to 3 the row stream loads its bank while the column stream is combined. In phases 4 to 7 the roles are swapped. Sums go to the even-coefficient path and differences go to the odd-coefficient path. Each result carries a dimension tag and its pair index. With only the row stream active, the arithmetic does useful work in half of the cycles. With both streams active, it does useful work in every cycle.

Upstream logic keeps its vectors aligned to the phase it sees on `phase_o`. `POINTS` must be a power of two, at least 4.

Top module: `dbf_butterfly_stage`

## Requirements
- R1: While `rst_ni` is low, `out_valid_o` is 0 and `phase_o` is 0. Both stay so until the first clock edge after release.
- R2: `phase_o` advances by one every cycle and wraps from 7 to 0. Phases 0–3 form half A and phases 4–7 form half B.
- R3: The row sample taken at phase p (p = 0..3) is x_p. The row sample taken at phase 4+k is x_{4+k}. One cycle later the block shows: `out_valid_o`=1, `dim_o`=0, `idx_o`=3−k, `sum_o`=x_{3−k}+x_{4+k} and `diff_o`=x_{3−k}−x_{4+k}.
- R4: The column sample taken at phase 4+k is y_k. The column sample taken at phase k (k = 0..3, next period) is y_{4+k}. One cycle later the block shows: `dim_o`=1, `idx_o`=3−k, `sum_o`=y_{3−k}+y_{4+k} and `diff_o`=y_{3−k}−y_{4+k}.
- R5: Inputs are two's complement numbers of `DATA_W` bits. `sum_o` and `diff_o` are exact two's complement results of `DATA_W`+1 bits for every input value, including −2048 and 2047 at the default width.
- R6: A result is valid only if both the incoming sample and its stored partner were marked valid. Otherwise `out_valid_o` is 0 in that cycle.
- R7: When both streams run at once, row results appear only in the cycle after a half-B cycle and column results only in the cycle after a half-A cycle. Neither stream's stored words are disturbed by the other stream.
- R8: With the row stream alone and valid in every cycle, 4 results are produced every 8 cycles. With both streams continuously valid, a result is produced in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_valid_i | input | 1 | Row sample present |
| row_data_i | input | DATA_W | Row sample, signed |
| col_valid_i | input | 1 | Column sample present |
| col_data_i | input | DATA_W | Column sample from transpose store, signed |
| phase_o | output | log2(POINTS) | Current schedule phase |
| out_valid_o | output | 1 | Result valid |
| dim_o | output | 1 | Result dimension: 0 row, 1 column |
| idx_o | output | log2(POINTS)-1 | Pair index i of the result |
| sum_o | output | DATA_W+1 | x_i + x_{7−i}, to even path |
| diff_o | output | DATA_W+1 | x_i − x_{7−i}, to odd path |

## Verification
Two functions share every cycle. One stream shifts a sample into its reorder bank while the other stream's vector passes through the shared adder/subtracter. The bench provokes this by driving both streams in every cycle with independent random values and with extreme values. It also clears the valid flags on chosen load and combine cycles. A model in the bench tracks both banks and checks each cycle's sum, difference, dimension tag, index and phase. It also counts the valid results of each segment, so the 50% and 100% use of the arithmetic are judged directly.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  typedef enum logic {
    DIM_ROW = 1'b0,
    DIM_COL = 1'b1
  } dim_e;
endpackage

// File: rtl/dbf_phase_ctrl.sv
module dbf_phase_ctrl #(
  parameter int unsigned POINTS = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  output logic [$clog2(POINTS)-1:0]   phase_o,
  output logic                        half_a_o,
  output logic [$clog2(POINTS)-2:0]   slot_o
);
  localparam int unsigned PH_W   = $clog2(POINTS);
  localparam int unsigned SLOT_W = PH_W - 1;

  logic [PH_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_q == PH_W'(POINTS - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o  = cnt_q;
  assign half_a_o = ~cnt_q[PH_W-1];
  assign slot_o   = cnt_q[SLOT_W-1:0];
endmodule

// File: rtl/dbf_reorder_bank.sv
module dbf_reorder_bank #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       shift_en_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       valid_i,
  input  logic [$clog2(DEPTH)-1:0]   rd_sel_i,
  output logic [DATA_W-1:0]          data_o,
  output logic                       valid_o
);
  typedef struct packed {
    logic              v;
    logic [DATA_W-1:0] d;
  } word_t;

  word_t word_q [DEPTH];

  // word 0 takes the newest sample; after DEPTH shifts word j holds sample DEPTH-1-j
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    word_t nxt;
    if (g == 0) begin : g_head
      assign nxt = '{v: valid_i, d: data_i};
    end else begin : g_body
      assign nxt = word_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[g] <= '0;
      end else if (shift_en_i) begin
        word_q[g] <= nxt;
      end
    end
  end

  assign data_o  = word_q[rd_sel_i].d;
  assign valid_o = word_q[rd_sel_i].v;
endmodule

// File: rtl/dbf_addsub.sv
module dbf_addsub
  import dbf_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_col_i,
  input  logic [DATA_W-1:0] row_near_i,
  input  logic [DATA_W-1:0] row_far_i,
  input  logic              row_ok_i,
  input  logic [DATA_W-1:0] col_near_i,
  input  logic [DATA_W-1:0] col_far_i,
  input  logic              col_ok_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              valid_o,
  output logic [DATA_W:0]   sum_o,
  output logic [DATA_W:0]   diff_o,
  output dim_e              dim_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [DATA_W-1:0]  near, far;
  logic               ok;
  logic signed [DATA_W:0] near_x, far_x;

  logic               valid_q;
  logic [DATA_W:0]    sum_q, diff_q;
  dim_e               dim_q;
  logic [IDX_W-1:0]   idx_q;

  // operand steering: one adder/subtracter pair for both streams
  always_comb begin
    if (sel_col_i) begin
      near = col_near_i;
      far  = col_far_i;
      ok   = col_ok_i;
    end else begin
      near = row_near_i;
      far  = row_far_i;
      ok   = row_ok_i;
    end
  end

  assign near_x = $signed({near[DATA_W-1], near});
  assign far_x  = $signed({far[DATA_W-1], far});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      sum_q   <= '0;
      diff_q  <= '0;
      dim_q   <= DIM_ROW;
      idx_q   <= '0;
    end else begin
      valid_q <= ok;
      if (ok) begin
        sum_q  <= near_x + far_x;
        diff_q <= near_x - far_x;
        dim_q  <= sel_col_i ? DIM_COL : DIM_ROW;
        idx_q  <= idx_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign sum_o   = sum_q;
  assign diff_o  = diff_q;
  assign dim_o   = dim_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/dbf_butterfly_stage.sv
module dbf_butterfly_stage
  import dbf_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned POINTS = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        row_valid_i,
  input  logic [DATA_W-1:0]           row_data_i,
  input  logic                        col_valid_i,
  input  logic [DATA_W-1:0]           col_data_i,
  output logic [$clog2(POINTS)-1:0]   phase_o,
  output logic                        out_valid_o,
  output logic                        dim_o,
  output logic [$clog2(POINTS)-2:0]   idx_o,
  output logic [DATA_W:0]             sum_o,
  output logic [DATA_W:0]             diff_o
);
  localparam int unsigned HALF  = POINTS / 2;
  localparam int unsigned IDX_W = $clog2(POINTS) - 1;

  logic              half_a;
  logic [IDX_W-1:0]  slot;
  logic [IDX_W-1:0]  pair_idx;

  logic [DATA_W-1:0] row_near, col_near;
  logic              row_near_v, col_near_v;
  dim_e              dim_q;

  dbf_phase_ctrl #(.POINTS(POINTS)) i_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phase_o  (phase_o),
    .half_a_o (half_a),
    .slot_o   (slot)
  );

  // row vectors load in half A, column vectors load in half B
  dbf_reorder_bank #(.DATA_W(DATA_W), .DEPTH(HALF)) i_row_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (half_a),
    .data_i     (row_data_i),
    .valid_i    (row_valid_i),
    .rd_sel_i   (slot),
    .data_o     (row_near),
    .valid_o    (row_near_v)
  );

  dbf_reorder_bank #(.DATA_W(DATA_W), .DEPTH(HALF)) i_col_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (~half_a),
    .data_i     (col_data_i),
    .valid_i    (col_valid_i),
    .rd_sel_i   (slot),
    .data_o     (col_near),
    .valid_o    (col_near_v)
  );

  assign pair_idx = IDX_W'(HALF - 1) - slot;

  dbf_addsub #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_addsub (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_col_i  (half_a),
    .row_near_i (row_near),
    .row_far_i  (row_data_i),
    .row_ok_i   (row_valid_i & row_near_v),
    .col_near_i (col_near),
    .col_far_i  (col_data_i),
    .col_ok_i   (col_valid_i & col_near_v),
    .idx_i      (pair_idx),
    .valid_o    (out_valid_o),
    .sum_o      (sum_o),
    .diff_o     (diff_o),
    .dim_o      (dim_q),
    .idx_o      (idx_o)
  );

  assign dim_o = dim_q;
endmodule

// File: rtl/dbf_butterfly_checker.sv
module dbf_butterfly_checker
  import dbf_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned POINTS = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        row_valid_i,
  input logic [DATA_W-1:0]           row_data_i,
  input logic                        col_valid_i,
  input logic [DATA_W-1:0]           col_data_i,
  input logic [$clog2(POINTS)-1:0]   phase_o,
  input logic                        out_valid_o,
  input logic                        dim_o,
  input logic [$clog2(POINTS)-2:0]   idx_o,
  input logic [DATA_W:0]             sum_o,
  input logic [DATA_W:0]             diff_o
);
  localparam int unsigned PH_W  = $clog2(POINTS);
  localparam int unsigned IDX_W = PH_W - 1;
  localparam int unsigned HALF  = POINTS / 2;

  logic [DATA_W-1:0]      prev_row, prev_col;
  logic signed [DATA_W+1:0] sum_x, diff_x, gap, row_x2, col_x2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_row <= '0;
      prev_col <= '0;
    end else begin
      prev_row <= row_data_i;
      prev_col <= col_data_i;
    end
  end

  assign sum_x  = $signed({sum_o[DATA_W], sum_o});
  assign diff_x = $signed({diff_o[DATA_W], diff_o});
  assign gap    = sum_x - diff_x;
  assign row_x2 = $signed({prev_row[DATA_W-1], prev_row, 1'b0});
  assign col_x2 = $signed({prev_col[DATA_W-1], prev_col, 1'b0});

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && phase_o == '0));

  assert_phase_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != PH_W'(POINTS - 1)) |=> (phase_o == $past(phase_o) + 1'b1));

  assert_phase_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_W'(POINTS - 1)) |=> (phase_o == '0));

  assert_pair_index_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (idx_o == IDX_W'(HALF - 1) - $past(phase_o[IDX_W-1:0])));

  assert_no_overflow_row_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && dim_o == DIM_ROW) |-> (gap == row_x2));

  assert_no_overflow_col_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && dim_o == DIM_COL) |-> (gap == col_x2));

  assert_row_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o >= PH_W'(HALF) && !row_valid_i) |=> !out_valid_o);

  assert_col_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o < PH_W'(HALF) && !col_valid_i) |=> !out_valid_o);

  assert_row_half_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && dim_o == DIM_ROW) |-> ($past(phase_o) >= PH_W'(HALF)));

  assert_col_half_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && dim_o == DIM_COL) |-> ($past(phase_o) < PH_W'(HALF)));
endmodule

bind dbf_butterfly_stage dbf_butterfly_checker #(
  .DATA_W (DATA_W),
  .POINTS (POINTS)
) i_dbf_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .row_valid_i (row_valid_i),
  .row_data_i  (row_data_i),
  .col_valid_i (col_valid_i),
  .col_data_i  (col_data_i),
  .phase_o     (phase_o),
  .out_valid_o (out_valid_o),
  .dim_o       (dim_o),
  .idx_o       (idx_o),
  .sum_o       (sum_o),
  .diff_o      (diff_o)
);

// File: tb/test_dbf_butterfly_stage.sv
`timescale 1ns/1ps
module test_dbf_butterfly_stage;
  localparam int W  = 12;
  localparam int P  = 8;
  localparam int H  = 4;
  localparam int PW = 3;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          row_valid_i, col_valid_i;
  logic [W-1:0]  row_data_i, col_data_i;
  logic [PW-1:0] phase_o;
  logic          out_valid_o, dim_o;
  logic [IW-1:0] idx_o;
  logic [W:0]    sum_o, diff_o;

  always #5 clk = ~clk;

  dbf_butterfly_stage #(.DATA_W(W), .POINTS(P)) i_dbf_butterfly_stage (
    .clk_i(clk), .rst_ni(rst_ni),
    .row_valid_i(row_valid_i), .row_data_i(row_data_i),
    .col_valid_i(col_valid_i), .col_data_i(col_data_i),
    .phase_o(phase_o), .out_valid_o(out_valid_o), .dim_o(dim_o),
    .idx_o(idx_o), .sum_o(sum_o), .diff_o(diff_o)
  );

  typedef struct {
    bit    v;
    bit    dim;
    int    idx;
    int    sum;
    int    diff;
    int    ph;
    int    seg;
    string req;
  } exp_t;

  exp_t  q[$];
  exp_t  e;
  int    checks = 0, errors = 0;
  int    seg_valid[8];
  int    bp = 0, cur_seg = 0;
  int    rs[H], cs[H];
  bit    rsv[H], csv[H];
  bit    done = 1'b0;

  function automatic int rnd();
    return int'($urandom_range(4095)) - 2048;
  endfunction

  // driver: applies one cycle of stimulus at a falling edge and queues the expected result
  task automatic drive(bit rv, int rd, bit cv, int cd, string req);
    exp_t x;
    int   k;
    row_valid_i = rv; row_data_i = rd[W-1:0];
    col_valid_i = cv; col_data_i = cd[W-1:0];
    x.seg = cur_seg; x.req = req; x.ph = (bp + 1) % P;
    if (bp < H) begin
      k = bp;
      rs[k] = rd; rsv[k] = rv;
      x.dim = 1'b1; x.idx = H - 1 - k;
      x.v = cv && csv[H-1-k];
      x.sum = cs[H-1-k] + cd; x.diff = cs[H-1-k] - cd;
    end else begin
      k = bp - H;
      cs[k] = cd; csv[k] = cv;
      x.dim = 1'b0; x.idx = H - 1 - k;
      x.v = rv && rsv[H-1-k];
      x.sum = rs[H-1-k] + rd; x.diff = rs[H-1-k] - rd;
    end
    q.push_back(x);
    bp = (bp + 1) % P;
    @(negedge clk);
  endtask

  // monitor: compares each registered result just after the edge that produced it
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (int'(phase_o) != e.ph) begin
        errors++;
        $display("FAIL R2: phase=%0d expected %0d", phase_o, e.ph);
      end
      checks++;
      if (e.v) begin
        if (!(out_valid_o && dim_o == e.dim && int'(idx_o) == e.idx &&
              $signed(sum_o) == e.sum && $signed(diff_o) == e.diff)) begin
          errors++;
          $display("FAIL %s: valid=%0b dim=%0b idx=%0d sum=%0d diff=%0d expected valid=1 dim=%0b idx=%0d sum=%0d diff=%0d",
                   e.req, out_valid_o, dim_o, idx_o, $signed(sum_o), $signed(diff_o),
                   e.dim, e.idx, e.sum, e.diff);
        end
      end else if (out_valid_o) begin
        errors++;
        $display("FAIL %s: valid=1 expected valid=0 (dim=%0b idx=%0d)", e.req, dim_o, idx_o);
      end
      if (out_valid_o) seg_valid[e.seg]++;
    end
  end

  task automatic check_count(string req, int seg, int expv);
    checks++;
    if (seg_valid[seg] != expv) begin
      errors++;
      $display("FAIL %s: segment %0d results=%0d expected %0d", req, seg, seg_valid[seg], expv);
    end
  endtask

  initial begin
    rst_ni = 1'b1; row_valid_i = 0; col_valid_i = 0; row_data_i = '0; col_data_i = '0;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (out_valid_o !== 1'b0 || phase_o !== '0) begin
      errors++;
      $display("FAIL R1: valid=%0b phase=%0d expected valid=0 phase=0", out_valid_o, phase_o);
    end
    rst_ni = 1'b1;

    cur_seg = 0;  // R3 row stream alone
    for (int n = 0; n < 4 * P; n++) drive(1, rnd(), 0, 0, "R3");

    cur_seg = 1;  // R4 column stream alone
    for (int n = 0; n < 5 * P; n++) drive(0, 0, 1, rnd(), "R4");

    cur_seg = 2;  // warm-up for both streams
    for (int n = 0; n < P; n++) drive(1, rnd(), 1, rnd(), "R7");

    cur_seg = 3;  // R7 both streams, steady state
    for (int n = 0; n < 4 * P; n++) drive(1, rnd(), 1, rnd(), "R7");

    cur_seg = 4;  // R5 extreme values
    for (int pr = 0; pr < 3; pr++) begin
      for (int c = 0; c < P; c++) begin
        int ri, ci, rv, cv;
        ri = c; ci = (c + H) % P;
        case (pr)
          0:       begin rv = (ri < H) ? 2047 : -2048; cv = (ci < H) ? -2048 : 2047; end
          1:       begin rv = -2048; cv = 2047; end
          default: begin rv = (ri < H) ? -2048 : 2047; cv = -2048; end
        endcase
        drive(1, rv, 1, cv, "R5");
      end
    end

    cur_seg = 5;  // R6 missing samples on both streams
    for (int pr = 0; pr < 3; pr++) begin
      for (int c = 0; c < P; c++) begin
        bit rvb, cvb;
        rvb = !((pr == 0 && (c == 1 || c == 5)) || (pr == 1 && c == 6));
        cvb = !((pr == 0 && c == 6) || (pr == 1 && c == 2) || (pr == 2 && c == 4));
        drive(rvb, rnd(), cvb, rnd(), "R6");
      end
    end

    cur_seg = 6;  // R6 idle drain
    drive(0, 0, 0, 0, "R6");
    drive(0, 0, 0, 0, "R6");

    check_count("R8", 0, 16);  // row alone: half the cycles
    check_count("R8", 1, 16);  // column alone after its first load
    check_count("R8", 3, 32);  // both streams: every cycle

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule